// File: doc/BRIEF.md
# EDO page-mode DRAM sequencer

This block sits between a simple request port and an 8-bit asynchronous DRAM with extended data out. A request carries a flat address, split into an 11-bit row (upper bits) and a 10-bit column (lower bits), a write flag and write data. The sequencer produces the row and column strobes, write enable, output enable and the shared address pins, and registers the bytes that come back.

Once a row has been opened it stays open. Later requests to the same row run as CAS-only page cycles. A request to another row first closes the open row, waits out the precharge time and then opens the new row. Writes are always early writes: write enable goes low one cycle before the column strobe falls, so the memory never drives its data pins during a write. A refresh request is served once the access in flight has finished. The open row is closed, then a column-before-row refresh cycle runs, and the block goes back to idle with no row open. The row is also closed by itself before the row-strobe low time reaches its upper limit.

Every timing is a parameter in clock cycles, so the block can run at another clock rate without change to its logic.

Top module: `edo_dram_seq`

## Requirements
- R1: During reset and right after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high once reset is released.
- R2: An access accepted with no row open puts the row (address bits 20..10) on `dram_addr` when `dram_ras_n` falls and the column (bits 9..0) when `dram_cas_n` falls. The strobes fall at least T_RCD+1 cycles apart, and a read gives `rd_valid` 1+T_RCD+1+T_CAS cycles after the accepting edge.
- R3: Read data is the value on `dram_dq_in` at the clock edge where `dram_cas_n` rises, after it has been low for T_CAS cycles. It is presented on `rd_data` with a one-cycle `rd_valid` pulse.
- R4: A request to the open row does not toggle `dram_ras_n`. A page read gives `rd_valid` 1+T_CAS cycles after acceptance, and `dram_cas_n` stays high at least T_CP cycles between page cycles.
- R5: On a write, `dram_we_n` is low and `dram_dq_oe` is high from one cycle before `dram_cas_n` falls until it rises. `dram_oe_n` stays high, `dram_we_n` never falls while the column strobe is low, and no `rd_valid` is produced.
- R6: A request to a different row raises `dram_ras_n`, which then stays high at least T_RP cycles before it falls again with the new row.
- R7: Every low phase of `dram_ras_n` lasts at least T_RAS cycles.
- R8: `dram_ras_n` is never low for more than T_RASP cycles. The row is closed even when no request is waiting.
- R9: A refresh request pulse on `ref_req` is served after the current access. Any open row is closed, `dram_cas_n` falls while `dram_ras_n` is high and `dram_we_n` is high, and `dram_ras_n` then stays low T_RAS cycles. `ref_done` pulses for one cycle, and the next access starts from idle.
- R10: While a refresh is pending, `req_ready` is low. A request held meanwhile is accepted after the refresh and completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Row in bits 20..10, column in bits 9..0 |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Captured read byte |
| ref_req | input | 1 | Refresh request pulse |
| ref_done | output | 1 | One-cycle pulse at the end of a refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Write data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the memory |

## Verification
With the default timings, a read that finds no row open returns `rd_valid` exactly 6 cycles after the accepting edge, and a page read returns it after 3 cycles. The bench counts cycles from the edge on which the request was taken and compares that count with these figures. A refresh-pending request must see `req_ready` low one cycle after `ref_req`, and the row strobe must be high within T_RASP cycles of opening. A monitor sampling at the falling clock edge measures every strobe low and high run against T_RAS, T_RP, T_RCD+1 and T_CP, so a timing breach shows up in the cycle it happens.

// File: rtl/edo_dram_seq.sv
module edo_dram_seq #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_CP   = 2,
  parameter int T_RP   = 5,
  parameter int T_RAS  = 8,
  parameter int T_CSR  = 1,
  parameter int T_RASP = 12000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    ref_req,
  output logic                    ref_done,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [ROW_W-1:0]        dram_addr,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);
  localparam int CW       = $clog2(T_RASP + 2) + 1;
  localparam int RASP_LIM = T_RASP - T_CAS - 4;
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [2:0] {
    S_IDLE, S_RSU, S_ACT, S_COL, S_CASL, S_OPEN, S_PRE, S_CBRC
  } st_base_t;
  typedef enum logic [3:0] {
    I_IDLE, I_RSU, I_ACT, I_COL, I_CASL, I_OPEN, I_PRE, I_CBRC, I_CBRR
  } st_t;

  st_t st, st_d;
  logic [CW-1:0]     cnt, ras_cnt;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q, ref_pend;
  logic [DATA_W-1:0] wd_q;

  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];
  wire hit     = (req_row == row_q);
  wire ras_low = st inside {I_ACT, I_COL, I_CASL, I_OPEN, I_CBRR};
  wire cas_low = st inside {I_CASL, I_CBRC, I_CBRR};
  wire io      = st inside {I_COL, I_CASL};
  wire page_ok = ras_cnt < CW'(RASP_LIM);
  wire cp_ok   = (cnt + CW'(2)) >= CW'(T_CP);
  wire ras_ok  = ras_cnt >= CW'(T_RAS - 1);

  assign req_ready = !ref_pend &&
                     ((st == I_IDLE) || (st == I_OPEN && hit && page_ok && cp_ok));
  wire accept = req_valid && req_ready;

  always_comb begin
    st_d = st;
    unique case (st)
      I_IDLE: if (ref_pend) st_d = I_CBRC;
              else if (req_valid) st_d = I_RSU;
      I_RSU:  st_d = I_ACT;
      I_ACT:  if (cnt == CW'(T_RCD - 1)) st_d = I_COL;
      I_COL:  st_d = I_CASL;
      I_CASL: if (cnt == CW'(T_CAS - 1)) st_d = I_OPEN;
      I_OPEN: if (accept) st_d = I_COL;
              else if (((req_valid && !hit) || ref_pend || !page_ok) && ras_ok)
                st_d = I_PRE;
      I_PRE:  if (cnt == CW'(T_RP - 1)) st_d = I_IDLE;
      I_CBRC: if (cnt == CW'(T_CSR - 1)) st_d = I_CBRR;
      I_CBRR: if (cnt == CW'(T_RAS - 1)) st_d = I_PRE;
      default: st_d = I_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= I_IDLE;
      cnt      <= '0;
      ras_cnt  <= '0;
      row_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      ref_pend <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ref_done <= 1'b0;
    end else begin
      st       <= st_d;
      cnt      <= (st_d != st) ? '0 : (cnt == CMAX ? cnt : cnt + CW'(1));
      ras_cnt  <= ras_low ? (ras_cnt == CMAX ? ras_cnt : ras_cnt + CW'(1)) : '0;
      ref_pend <= ref_req | (ref_pend & (st != I_IDLE));
      if (accept) begin
        row_q <= req_row;
        col_q <= req_col;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
      rd_valid <= (st == I_CASL) && (st_d == I_OPEN) && !wr_q;
      if ((st == I_CASL) && (st_d == I_OPEN) && !wr_q) rd_data <= dram_dq_in;
      ref_done <= (st == I_CBRR) && (st_d == I_PRE);
    end
  end

  assign dram_ras_n  = !ras_low;
  assign dram_cas_n  = !cas_low;
  assign dram_we_n   = !(io && wr_q);
  assign dram_oe_n   = !(io && !wr_q);
  assign dram_dq_oe  = io && wr_q;
  assign dram_dq_out = wd_q;
  assign dram_addr   = io ? ROW_W'(col_q) : row_q;

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= CW'(T_RP);
    else        hi_cnt <= dram_ras_n ? (hi_cnt == CMAX ? hi_cnt : hi_cnt + CW'(1)) : '0;
  end

  // R6
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_cnt >= CW'(T_RP));
  // R7
  ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> ras_cnt >= CW'(T_RAS));
  // R8
  ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_cnt <= CW'(T_RASP));
  // R2
  rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> ras_cnt > CW'(T_RCD));
  // R5
  early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n && !dram_we_n) |-> ($past(dram_we_n) == 1'b0 && $past(dram_dq_oe)));
  // R5
  drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (dram_oe_n && !dram_we_n));
  // R9
  cbr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> (dram_we_n && $past(!dram_cas_n)));
  // R3
  rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($rose(dram_cas_n) && !dram_ras_n));
endmodule

// File: tb/tb_edo_dram_seq.sv
module tb_edo_dram_seq;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 2, T_RP = 5, T_RAS = 8, RASP = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0, ref_req = 0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, ref_done;
  logic [7:0] rd_data, dram_dq_out, dram_dq_in;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;

  edo_dram_seq #(.T_RASP(RASP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_done(ref_done),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] pat(int a);
    return 8'(a ^ (a >> 8) ^ (a >> 16)) ^ 8'hA5;
  endfunction

  // memory model
  logic [7:0] mem [int];
  logic [10:0] m_row = '0;
  logic [7:0]  m_dout = '0;
  int cbr_n = 0, rasfall_n = 0, v_cbrwe = 0, v_wdrv = 0;
  assign dram_dq_in = m_dout;

  always @(negedge dram_ras_n) if (rst_n) begin
    if (!dram_cas_n) begin cbr_n++; if (!dram_we_n) v_cbrwe++; end
    else begin m_row = dram_addr; rasfall_n++; end
  end
  always @(negedge dram_cas_n) if (rst_n && !dram_ras_n) begin
    int a;
    a = int'({m_row, dram_addr[9:0]});
    if (!dram_we_n) begin
      if (!dram_dq_oe) v_wdrv++;
      mem[a] = dram_dq_out;
    end else m_dout = mem.exists(a) ? mem[a] : pat(a);
  end

  // timing monitor
  int lo_run = 0, hi_run = 100, cas_hi = 100;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  int v_rasmin = 0, v_rasp = 0, v_rp = 0, v_rcd = 0, v_cp = 0, v_oe = 0, v_late = 0;
  always @(negedge clk) if (rst_n) begin
    if (!dram_ras_n) begin
      if (p_ras) begin if (hi_run < T_RP) v_rp++; lo_run = 0; end
      lo_run++;
      if (lo_run > RASP) v_rasp++;
    end else begin
      if (!p_ras) begin if (lo_run < T_RAS) v_rasmin++; hi_run = 0; end
      hi_run++;
    end
    if (!dram_cas_n && p_cas && !dram_ras_n) begin
      if (lo_run - 1 < T_RCD + 1) v_rcd++;
      if (cas_hi < T_CP) v_cp++;
    end
    cas_hi = dram_cas_n ? cas_hi + 1 : 0;
    if (!dram_oe_n && !dram_we_n) v_oe++;
    if (dram_dq_oe && dram_we_n) v_oe++;
    if (!dram_we_n && p_we && !dram_cas_n) v_late++;
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(bit w, logic [20:0] a, logic [7:0] d, output int lat, output logic [7:0] q);
    int acc;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    acc = cyc; req_valid = 0;
    lat = -1; q = '0;
    if (w) repeat (4) @(negedge clk);
    else for (int i = 0; i < 40; i++) begin
      if (rd_valid) begin lat = cyc - acc; q = rd_data; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes", {dram_ras_n,dram_cas_n,dram_we_n,dram_oe_n}, 15);
    chk(!dram_dq_oe && !rd_valid, "R1 dq_oe/rd_valid", {dram_dq_oe,rd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_write_read();
    int lat, rf; logic [7:0] q; logic [20:0] a;
    a = {11'h123, 10'h005};
    access(1, a, 8'h3C, lat, q);
    chk(mem.exists(int'(a)) && mem[int'(a)] == 8'h3C, "R5 write stored", mem.exists(int'(a)) ? mem[int'(a)] : -1, 8'h3C);
    chk(!rd_valid, "R5 no rd_valid", rd_valid, 0);
    rf = rasfall_n;
    access(0, a, 0, lat, q);
    chk(q == 8'h3C, "R3 read data", q, 8'h3C);
    chk(lat == 1 + T_CAS, "R4 page latency", lat, 1 + T_CAS);
    chk(rasfall_n == rf, "R4 no row reopen", rasfall_n - rf, 0);
  endtask

  task automatic t_miss();
    int lat, rf; logic [7:0] q; logic [20:0] a;
    a = {11'h2A7, 10'h3FF};
    rf = rasfall_n;
    access(0, a, 0, lat, q);
    chk(q == pat(int'(a)), "R6 miss data", q, pat(int'(a)));
    chk(rasfall_n == rf + 1, "R6 new row opened", rasfall_n - rf, 1);
    chk(lat == 1 + T_RCD + 1 + T_CAS, "R2 closed-row latency", lat, 1 + T_RCD + 1 + T_CAS);
  endtask

  task automatic t_page();
    int lat, rf; logic [7:0] q;
    access(1, {11'h055, 10'd1}, 8'h11, lat, q);
    rf = rasfall_n;
    for (int i = 2; i <= 3; i++) access(1, {11'h055, 10'(i)}, 8'(8'h10 + i), lat, q);
    for (int i = 1; i <= 3; i++) begin
      access(0, {11'h055, 10'(i)}, 0, lat, q);
      chk(q == ((i == 1) ? 8'h11 : 8'(8'h10 + i)), "R4 page data", q, (i == 1) ? 8'h11 : 8'h10 + i);
      chk(lat == 1 + T_CAS, "R4 page read latency", lat, 1 + T_CAS);
    end
    chk(rasfall_n == rf, "R4 row held", rasfall_n - rf, 0);
  endtask

  task automatic t_refresh();
    int lat, rf, cb, got; logic [7:0] q;
    cb = cbr_n;
    @(negedge clk); ref_req = 1;
    @(negedge clk); ref_req = 0;
    got = 0;
    for (int i = 0; i < 60; i++) begin
      if (ref_done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got == 1, "R9 ref_done", got, 1);
    chk(cbr_n == cb + 1, "R9 refresh cycle", cbr_n - cb, 1);
    rf = rasfall_n;
    access(0, {11'h055, 10'd2}, 0, lat, q);
    chk(rasfall_n == rf + 1 && lat == 1 + T_RCD + 1 + T_CAS, "R9 restart from idle", lat, 1 + T_RCD + 1 + T_CAS);
    chk(q == 8'h12, "R9 data after refresh", q, 8'h12);
  endtask

  task automatic t_ready();
    int lat, cb; logic [7:0] q;
    cb = cbr_n;
    @(negedge clk); ref_req = 1;
    @(negedge clk); ref_req = 0; req_addr = {11'h055, 10'd3}; #1;
    chk(!req_ready, "R10 ready low while refresh pending", req_ready, 0);
    access(0, {11'h055, 10'd3}, 0, lat, q);
    chk(cbr_n == cb + 1, "R10 refresh before request", cbr_n - cb, 1);
    chk(q == 8'h13, "R10 held request data", q, 8'h13);
  endtask

  task automatic t_rasp();
    int lat; logic [7:0] q;
    access(0, {11'h600, 10'd7}, 0, lat, q);
    repeat (RASP + 20) @(negedge clk);
    chk(dram_ras_n, "R8 row closed with no request", dram_ras_n, 1);
    chk(v_rasp == 0, "R8 RAS low limit", v_rasp, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    t_reset();
    t_write_read();
    t_miss();
    t_page();
    t_refresh();
    t_ready();
    t_rasp();
    repeat (5) @(negedge clk);
    chk(v_rcd == 0, "R2 RAS-to-CAS spacing", v_rcd, 0);
    chk(v_rp == 0, "R6 precharge time", v_rp, 0);
    chk(v_rasmin == 0, "R7 RAS minimum low", v_rasmin, 0);
    chk(v_cp == 0, "R4 CAS precharge", v_cp, 0);
    chk(v_oe == 0, "R5 OE/WE/drive direction", v_oe, 0);
    chk(v_late == 0 && v_wdrv == 0, "R5 early write", v_late + v_wdrv, 0);
    chk(v_cbrwe == 0, "R9 WE high at refresh", v_cbrwe, 0);
    report();
  end
endmodule